// File: doc/BRIEF.md
# Event Status and Interrupt Gating Register

This block gathers one-cycle event pulses from a card host controller's command path, data path and card-detect logic. It holds them as sticky flags in a single 32-bit status word. Software clears a flag by writing a one to its position; a zero in the written word leaves that flag alone. Three buffer and clock-run levels are not stored: they are passed through into the status word as they arrive.

A separate 16-bit enable register selects which status conditions may raise the single interrupt line. Its bit positions do not match the status bit positions. The interrupt is the registered OR of every selected condition. The block also reports:
- a summary of the error flags;
- a two-bit write-CRC result code, captured together with the write-CRC error. Code value 2 means the card returned no CRC status token.

The logic that produces the events lies outside the block. It only latches, clears, gates and combines them.

Top module: `sd_status_irq`

## Requirements
- R1: After reset the stored flags, the write-CRC code, the enable register and the interrupt line are all zero, so the status word shows only the three live levels.
- R2: A pulse on `evt_i[n]` sets status bit n at the next clock edge when n is a sticky position. The sticky positions are 31 insertion, 30 removal, 25 underrun, 24 overflow, 14 SDIO, 13 command response end, 12 write done, 11 read/transfer done, 5 response CRC error, 3 read CRC error, 2 write CRC error, 1 response timeout and 0 read timeout. The flag then stays set until it is cleared.
- R3: A write with `clr_we_i` high clears every sticky flag whose bit in `clr_data_i` is one. Flags whose bit is zero are unchanged.
- R4: A flag whose event arrives in the same cycle as a clear write for that bit stays set.
- R5: Status bits 8 (bus clock running), 7 (read buffer ready) and 6 (write buffer ready) follow their input levels in the same cycle. Clear writes and event pulses on these positions do not affect them. Every status bit outside the sticky, live and code positions reads zero, whatever events arrive there.
- R6: `err_any_o` is high exactly when any of status bits 0, 1, 2, 3 or 5 is set (mask 0x2F).
- R7: Status bits 10:9 carry the write-CRC code. It is loaded from `wcrc_code_i` whenever `evt_i[2]` pulses, and a later pulse overwrites it. It reads zero whenever bit 2 is clear, so clearing bit 2 without a new pulse returns it to zero.
- R8: The enable register is loaded with `ien_data_i` when `ien_we_i` is high. Only bits 0, 1, 2, 3, 4, 13, 14 and 15 are kept; the other bits read zero. Enable bit 0 gates status 11, bit 1 status 12, bit 2 status 13, bit 3 status 6, bit 4 status 7, bit 13 status 14, bit 14 status 30 and bit 15 status 31. `irq_o` equals, one clock later, the OR of the gated conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 32 | Event pulses, one per status position |
| wcrc_code_i | input | 2 | Write-CRC result code, sampled with `evt_i[2]` |
| bus_clk_run_i | input | 1 | Level: card bus clock running |
| rd_rdy_i | input | 1 | Level: read buffer ready |
| wr_rdy_i | input | 1 | Level: write buffer ready |
| clr_we_i | input | 1 | Write strobe for the clear word |
| clr_data_i | input | 32 | Clear word, ones clear flags |
| ien_we_i | input | 1 | Write strobe for the enable register |
| ien_data_i | input | 16 | New enable register value |
| status_o | output | 32 | Status word |
| ien_o | output | 16 | Enable register readback |
| err_any_o | output | 1 | Error summary |
| irq_o | output | 1 | Interrupt line |

## Verification
The stored flags and the code field are visible on `status_o` in the cycle after the edge that changed them. A lost set, a stray clear or a wrong priority between event and clear therefore shows on the next read.

Enable register corruption appears directly on `ien_o`. A wrong gate mapping shows as a mismatch on `irq_o` one cycle after the condition becomes visible.

The bench keeps an arithmetic model of every port and compares all of them after every edge. It first runs single-bit sweeps over each status position, each level combination, each code value and each enable bit, and then runs a long stretch of random traffic.

// File: rtl/sd_status_irq.sv
module sd_status_irq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] evt_i,
  input  logic [1:0]  wcrc_code_i,
  input  logic        bus_clk_run_i,
  input  logic        rd_rdy_i,
  input  logic        wr_rdy_i,
  input  logic        clr_we_i,
  input  logic [31:0] clr_data_i,
  input  logic        ien_we_i,
  input  logic [15:0] ien_data_i,
  output logic [31:0] status_o,
  output logic [15:0] ien_o,
  output logic        err_any_o,
  output logic        irq_o
);

  localparam logic [31:0] STICKY_MASK = 32'hC300_782F;
  localparam logic [31:0] ERR_MASK    = 32'h0000_002F;
  localparam logic [15:0] IEN_MASK    = 16'hE01F;

  logic [31:0] flags_q, flags_d, clr_mask;
  logic [1:0]  code_q, code_d;
  logic [15:0] ien_q, irq_src;
  logic        irq_q;

  assign clr_mask = clr_we_i ? clr_data_i : 32'h0;
  assign flags_d  = ((flags_q & ~clr_mask) | evt_i) & STICKY_MASK;
  assign code_d   = evt_i[2] ? wcrc_code_i : (flags_d[2] ? code_q : 2'b00);

  assign status_o = flags_q
                  | {21'h0, code_q, bus_clk_run_i, rd_rdy_i, wr_rdy_i, 6'h0};

  assign irq_src  = {status_o[31], status_o[30], status_o[14], 8'h00,
                     status_o[7], status_o[6], status_o[13], status_o[12],
                     status_o[11]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      code_q  <= '0;
      ien_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      code_q  <= code_d;
      if (ien_we_i) ien_q <= ien_data_i & IEN_MASK;
      irq_q   <= |(irq_src & ien_q);
    end
  end

  assign ien_o     = ien_q;
  assign err_any_o = |(status_o & ERR_MASK);
  assign irq_o     = irq_q;

endmodule

module sd_status_irq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] evt_i,
  input logic        bus_clk_run_i,
  input logic        rd_rdy_i,
  input logic        wr_rdy_i,
  input logic        clr_we_i,
  input logic [31:0] clr_data_i,
  input logic [31:0] status_o,
  input logic [15:0] ien_o,
  input logic        err_any_o,
  input logic        irq_o
);
  localparam logic [31:0] STK = 32'hC300_782F;
  localparam logic [31:0] USED = 32'hC300_7FEF;

  logic [31:0] keep_w;
  logic [15:0] gated_w;
  assign keep_w  = status_o & STK & ~(clr_we_i ? clr_data_i : 32'h0);
  assign gated_w = ien_o & {status_o[31], status_o[30], status_o[14], 8'h00,
                            status_o[7], status_o[6], status_o[13],
                            status_o[12], status_o[11]};

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & $past(keep_w)) == $past(keep_w))); // R2
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & $past(evt_i & STK)) == $past(evt_i & STK))); // R4
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((status_o & $past(clr_data_i & ~evt_i & STK)) == 32'h0)); // R3
  AST_LIVE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[8:6] == {bus_clk_run_i, rd_rdy_i, wr_rdy_i}); // R5
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o & ~USED) == 32'h0); // R5
  AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[0] | status_o[1] | status_o[2] | status_o[3] | status_o[5])
      == err_any_o); // R6
  AST_CODE_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[2] |-> (status_o[10:9] == 2'b00)); // R7
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|gated_w))); // R8
  AST_IEN_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
    ien_o[12:5] == 8'h00); // R8
endmodule

bind sd_status_irq sd_status_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_clk_run_i(bus_clk_run_i),
  .rd_rdy_i(rd_rdy_i), .wr_rdy_i(wr_rdy_i), .clr_we_i(clr_we_i),
  .clr_data_i(clr_data_i), .status_o(status_o), .ien_o(ien_o),
  .err_any_o(err_any_o), .irq_o(irq_o)
);

// File: tb/test_sd_status_irq.sv
`timescale 1ns/1ps
module test_sd_status_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] evt = '0;
  logic [1:0]  code_in = '0;
  logic [2:0]  lvl = '0;
  logic        clr_we = 1'b0;
  logic [31:0] clr_d = '0;
  logic        ien_we = 1'b0;
  logic [15:0] ien_d = '0;
  logic [31:0] status;
  logic [15:0] ien;
  logic        err_any, irq;

  int tests = 0;
  int fails = 0;

  logic [31:0] flags_m = '0;
  logic [1:0]  code_m = '0;
  logic [15:0] ien_m = '0;
  logic        irq_m = 1'b0;

  always #2.5 clk = ~clk;

  sd_status_irq i_sd_status_irq (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wcrc_code_i(code_in),
    .bus_clk_run_i(lvl[2]), .rd_rdy_i(lvl[1]), .wr_rdy_i(lvl[0]),
    .clr_we_i(clr_we), .clr_data_i(clr_d), .ien_we_i(ien_we),
    .ien_data_i(ien_d), .status_o(status), .ien_o(ien),
    .err_any_o(err_any), .irq_o(irq)
  );

  function automatic logic [31:0] exp_status();
    return flags_m | ({30'h0, code_m} << 9) | ({29'h0, lvl} << 6);
  endfunction

  function automatic logic [15:0] src_of(logic [31:0] s);
    return {s[31], s[30], s[14], 8'h00, s[7], s[6], s[13], s[12], s[11]};
  endfunction

  task automatic one(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk(input string req);
    logic [31:0] s;
    s = exp_status();
    one(req, "status", status, s);
    one(req, "err_any", {31'h0, err_any}, {31'h0, |(s & 32'h2F)});
    one(req, "irq", {31'h0, irq}, {31'h0, irq_m});
    one(req, "ien", {16'h0, ien}, {16'h0, ien_m});
  endtask

  task automatic cyc();
    logic        irq_n;
    logic [31:0] clrm, nf;
    irq_n = |(src_of(exp_status()) & ien_m);
    @(posedge clk);
    if (!rst_n) begin
      flags_m = '0; code_m = '0; ien_m = '0; irq_m = 1'b0;
    end else begin
      clrm = clr_we ? clr_d : 32'h0;
      nf = ((flags_m & ~clrm) | evt) & 32'hC300_782F;
      if (evt[2]) code_m = code_in;
      else if (!nf[2]) code_m = 2'b00;
      if (ien_we) ien_m = ien_d & 16'hE01F;
      flags_m = nf;
      irq_m = irq_n;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    evt = '0; clr_we = 1'b0; clr_d = '0; ien_we = 1'b0; ien_d = '0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle();
    evt = 32'hFFFF_FFFF; clr_we = 1'b1; ien_we = 1'b1; ien_d = 16'hFFFF;
    cyc(); cyc();
    idle();
    cyc();
    chk("R1");
    rst_n = 1'b1;
    cyc();
    chk("R1");

    for (int i = 0; i < 32; i++) begin
      idle(); evt = 32'h1 << i; cyc(); chk("R2");
      idle(); cyc(); chk("R2");
      clr_we = 1'b1; clr_d = ~(32'h1 << i); cyc(); chk("R3");
      idle(); clr_we = 1'b1; clr_d = 32'h1 << i; evt = 32'h1 << i;
      cyc(); chk("R4");
      idle(); clr_we = 1'b1; clr_d = 32'h1 << i; cyc(); chk("R3");
      idle(); clr_we = 1'b1; clr_d = '1; cyc(); chk("R5");
    end

    for (int v = 0; v < 8; v++) begin
      idle(); lvl = 3'(v); evt = 32'h0000_01C0; clr_we = 1'b1;
      clr_d = 32'h0000_01C0; cyc(); chk("R5");
    end
    lvl = '0;

    for (int c = 0; c < 4; c++) begin
      idle(); evt = 32'h4; code_in = 2'(c); cyc(); chk("R7");
      idle(); cyc(); chk("R7");
      evt = 32'h4; code_in = 2'(3 - c); cyc(); chk("R7");
      idle(); clr_we = 1'b1; clr_d = 32'h0000_0600; cyc(); chk("R7");
      idle(); evt = 32'h1; clr_we = 1'b1; clr_d = 32'h5; cyc(); chk("R6");
      idle(); clr_we = 1'b1; clr_d = 32'h4; cyc(); chk("R7");
      idle(); clr_we = 1'b1; clr_d = '1; cyc(); chk("R6");
    end

    for (int e = 0; e < 16; e++) begin
      idle(); ien_we = 1'b1; ien_d = 16'h1 << e; cyc(); chk("R8");
      idle(); evt = 32'hC300_782F; lvl = 3'b011; cyc(); chk("R8");
      idle(); cyc(); chk("R8");
      clr_we = 1'b1; clr_d = '1; lvl = '0; cyc(); chk("R8");
      idle(); cyc(); chk("R8");
    end

    for (int n = 0; n < 3000; n++) begin
      evt    = $urandom() & $urandom();
      code_in = 2'($urandom());
      lvl    = 3'($urandom());
      clr_we = ($urandom() % 4) == 0;
      clr_d  = $urandom();
      ien_we = ($urandom() % 8) == 0;
      ien_d  = 16'($urandom());
      cyc();
      chk("R2 R3 R4 R5 R6 R7 R8 random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule